// File: doc/BRIEF.md
# Processor System Control Register File

This block holds the privileged control state of a processor core: the paging and protection control words, the extended feature word with its long-mode enable and active bits, the code and stack segment attribute words, the flags word (for its virtual-8086 bit), six segment bases with their effective bases, the debug address, status and control words, a timestamp offset, and the floating-point status word with its separately held stack-top field. Reads are combinational, selected by a 6-bit index. Writes go through one indexed write port, and all writes take effect at the clock edge.

Many writes change more than the register they name. Turning paging on or off while long mode is enabled makes long mode active or inactive. Changes that affect translation send one-cycle flush strobes to the instruction and data TLBs. Some writes also recompute a packed execution-mode word, which the instruction decoder uses directly from the `mode_word` output. Toggling the code segment's long bit zeroes or restores the effective bases of the four legacy segments. Indices that fall in the reserved control-register holes are rejected with an error pulse.

Index map: 0..15 control words (1, 5..7 and 9..15 reserved), 16 extended feature word, 17 code attributes, 18 stack attributes, 19 flags, 20 timestamp, 21 FPU status, 22 stack-top, 23..30 debug words 0..7, 31 mode word, 32..37 bases and 40..45 effective bases of segments ES, CS, SS, DS, FS, GS. Code attributes: bit 0 long, bit 1 default-size, bits 3:2 privilege level. Stack attributes: bit 1 default-size. Flags: bit 17 virtual-8086. Unmapped indices read zero and ignore writes.

Top module: `sysreg_file`

## Requirements
- R1: After reset every register reads zero, except debug status (index 29) = 0xFFFF0FF0 and debug control (index 30) = 0x400. All strobes and the error output are low.
- R2: A write to control word 0 stores the data with bit 4 forced to 1. If bit 31 (paging) changes while feature bit 8 (long enable) is 1, feature bit 10 (long active) takes the new bit 31.
- R3: Both full-flush strobes pulse for one cycle, in the cycle after the write, when a control word 0 write changes bit 31, or when a control word 4 write changes bit 4, 5 or 7. Other writes do not pulse them.
- R4: Every legal write to control word 3 pulses both non-global flush strobes for one cycle, in the cycle after the write.
- R5: The mode word has bit 0 = long, bits 3:1 = submode (0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit), bits 5:4 = code privilege, bit 6 = paging, bit 7 = protection enable. Long selects compatibility or 64-bit by the code long bit. Otherwise the submode is real without protection enable, and virtual-8086 or protected by the flags bit 17.
- R6: Mode word size fields use 1=16, 2=32, 3=64 bits: operand default/alternate in bits 9:8/11:10, address default/alternate in 13:12/15:14, stack in 17:16. Operand is 2/1 in 64-bit or with code default-size set, else 1/2. Address is 3/2 in 64-bit, else 2/1 with code default-size set, else 1/2. Stack is 3 in 64-bit, else 2 with stack default-size set, else 1.
- R7: The mode word is recomputed, from the values being written, only on writes to control word 0, code attributes, stack attributes or the mode word itself. Data written to the mode word is discarded.
- R8: A code-attribute write that sets the long bit clears the effective bases of ES, CS, SS and DS. One that clears it copies their bases into the effective bases.
- R9: A base write for ES/CS/SS/DS updates the matching effective base only outside 64-bit mode. FS/GS base writes always update it.
- R10: A timestamp read returns the last written value plus the cycles elapsed since that write, and increases by one each cycle.
- R11: An FPU status read returns the stored word with bits 13:11 replaced by the 3-bit stack-top register.
- R12: Debug words 4 and 5 alias debug status and control. A status write changes only bits 3:0 and 15:13. A control write changes only bits 7:0, 13 and 31:16.
- R13: A read (rd_en) or write to a reserved control index pulses acc_err one cycle later. A reserved read returns zero, and a reserved write changes no state and pulses no flush strobe.
- R14: A read in the same cycle as a write to the same register returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read qualifier, used for error reporting |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| mode_word | output | 18 | Derived execution-mode word |
| itlb_flush_all | output | 1 | Full instruction-TLB flush pulse |
| dtlb_flush_all | output | 1 | Full data-TLB flush pulse |
| itlb_flush_ng | output | 1 | Non-global instruction-TLB flush pulse |
| dtlb_flush_ng | output | 1 | Non-global data-TLB flush pulse |
| acc_err | output | 1 | Reserved-index access pulse |

## Verification
A wrong long-active bit or a stale mode word does not show up at once on its own register. It shows one cycle later as the wrong submode or wrong size fields on `mode_word`, and as effective bases that fail to clear or reload after the next code-attribute write. Flush strobes are checked in the exact cycle after each write, so a strobe that comes late, is missing, or fires on a reserved index shows up within one cycle. The timestamp offset and the masked debug fields are checked by reading back values that depend on the cycle count and on the bits the write was not allowed to change.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int IDX_W = 6;

    localparam logic [IDX_W-1:0] IX_CTL0  = 6'd0;
    localparam logic [IDX_W-1:0] IX_CTL2  = 6'd2;
    localparam logic [IDX_W-1:0] IX_CTL3  = 6'd3;
    localparam logic [IDX_W-1:0] IX_CTL4  = 6'd4;
    localparam logic [IDX_W-1:0] IX_CTL8  = 6'd8;
    localparam logic [IDX_W-1:0] IX_FEAT  = 6'd16;
    localparam logic [IDX_W-1:0] IX_CSA   = 6'd17;
    localparam logic [IDX_W-1:0] IX_SSA   = 6'd18;
    localparam logic [IDX_W-1:0] IX_FLG   = 6'd19;
    localparam logic [IDX_W-1:0] IX_TSC   = 6'd20;
    localparam logic [IDX_W-1:0] IX_FSW   = 6'd21;
    localparam logic [IDX_W-1:0] IX_FTOP  = 6'd22;
    localparam logic [IDX_W-1:0] IX_DBG0  = 6'd23;
    localparam logic [IDX_W-1:0] IX_DBG1  = 6'd24;
    localparam logic [IDX_W-1:0] IX_DBG2  = 6'd25;
    localparam logic [IDX_W-1:0] IX_DBG3  = 6'd26;
    localparam logic [IDX_W-1:0] IX_DBG4  = 6'd27;
    localparam logic [IDX_W-1:0] IX_DBG5  = 6'd28;
    localparam logic [IDX_W-1:0] IX_DBG6  = 6'd29;
    localparam logic [IDX_W-1:0] IX_DBG7  = 6'd30;
    localparam logic [IDX_W-1:0] IX_MODE  = 6'd31;
    localparam logic [2:0]       GRP_BASE = 3'b100;
    localparam logic [2:0]       GRP_EFF  = 3'b101;

    localparam int NSEG = 6;
    localparam int NLEG = 4;

    // bit positions
    localparam int C0_PE  = 0;
    localparam int C0_ET  = 4;
    localparam int C0_PG  = 31;
    localparam int FT_LME = 8;
    localparam int FT_LMA = 10;
    localparam int CA_L   = 0;
    localparam int CA_D   = 1;
    localparam int CA_DPL = 2;
    localparam int FL_VM  = 17;
    localparam int FSW_TOP_LO = 11;

    localparam logic [63:0] C4_FLUSH_MASK = 64'h0000_0000_0000_00B0;
    localparam logic [63:0] DST_WMASK     = 64'h0000_0000_0000_E00F;
    localparam logic [63:0] DCT_WMASK     = 64'h0000_0000_FFFF_20FF;
    localparam logic [63:0] DST_RESET     = 64'h0000_0000_FFFF_0FF0;
    localparam logic [63:0] DCT_RESET     = 64'h0000_0000_0000_0400;

    localparam logic [2:0] SUB_REAL   = 3'd0;
    localparam logic [2:0] SUB_PROT   = 3'd1;
    localparam logic [2:0] SUB_V86    = 3'd2;
    localparam logic [2:0] SUB_COMPAT = 3'd3;
    localparam logic [2:0] SUB_B64    = 3'd4;

    localparam logic [1:0] SZ16 = 2'd1;
    localparam logic [1:0] SZ32 = 2'd2;
    localparam logic [1:0] SZ64 = 2'd3;

    typedef struct packed {
        logic [1:0] stack;
        logic [1:0] alt_addr;
        logic [1:0] def_addr;
        logic [1:0] alt_op;
        logic [1:0] def_op;
        logic       prot;
        logic       paging;
        logic [1:0] cpl;
        logic [2:0] submode;
        logic       is_long;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic lma;
        logic pe;
        logic pg;
        logic vm;
        logic cs_l;
        logic cs_d;
        logic ss_d;
        logic [1:0] dpl;
    } mode_src_t;

    function automatic logic is_reserved(input logic [IDX_W-1:0] ix);
        logic r;
        r = 1'b0;
        if (ix < 6'd16) begin
            r = (ix == 6'd1) || ((ix >= 6'd5) && (ix <= 6'd7)) || (ix >= 6'd9);
        end
        return r;
    endfunction

endpackage

// File: rtl/sysreg_mode_calc.sv
module sysreg_mode_calc
    import sysreg_pkg::*;
(
    input  mode_src_t src,
    output mode_t     mode
);
    logic b64;

    always_comb begin
        mode = '0;
        mode.is_long = src.lma;
        if (src.lma) begin
            mode.submode = src.cs_l ? SUB_B64 : SUB_COMPAT;
        end else if (src.pe) begin
            mode.submode = src.vm ? SUB_V86 : SUB_PROT;
        end else begin
            mode.submode = SUB_REAL;
        end
        b64         = src.lma && src.cs_l;
        mode.cpl    = src.dpl;
        mode.paging = src.pg;
        mode.prot   = src.pe;

        if (b64 || src.cs_d) begin
            mode.def_op = SZ32;
            mode.alt_op = SZ16;
        end else begin
            mode.def_op = SZ16;
            mode.alt_op = SZ32;
        end

        if (b64) begin
            mode.def_addr = SZ64;
            mode.alt_addr = SZ32;
        end else if (src.cs_d) begin
            mode.def_addr = SZ32;
            mode.alt_addr = SZ16;
        end else begin
            mode.def_addr = SZ16;
            mode.alt_addr = SZ32;
        end

        if (b64)           mode.stack = SZ64;
        else if (src.ss_d) mode.stack = SZ32;
        else               mode.stack = SZ16;
    end
endmodule

// File: rtl/sysreg_tsc.sv
module sysreg_tsc #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] value
);
    logic [DW-1:0] cyc_q;
    logic [DW-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            off_q <= '0;
        end else begin
            cyc_q <= cyc_q + DW'(1);
            if (wr_en) off_q <= wdata - cyc_q;
        end
    end

    assign value = off_q + cyc_q;

    // R10: one cycle after a write the count reads the written value plus one
    a_r10_tsc_offset: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (value == $past(wdata) + DW'(1)));
endmodule

// File: rtl/sysreg_seg_bank.sv
module sysreg_seg_bank
    import sysreg_pkg::*;
#(
    parameter int DW    = 64,
    parameter int NS    = NSEG,
    parameter int NL    = NLEG
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_base,
    input  logic                   wr_eff,
    input  logic [2:0]             sel,
    input  logic [DW-1:0]          wdata,
    input  logic                   in_b64,
    input  logic                   l_rise,
    input  logic                   l_fall,
    output logic [NS-1:0][DW-1:0]  base_o,
    output logic [NS-1:0][DW-1:0]  eff_o
);
    for (genvar s = 0; s < NS; s++) begin : g_seg
        localparam bit LEGACY = (s < NL);
        logic hit;
        assign hit = (sel == 3'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_o[s] <= '0;
            end else if (wr_base && hit) begin
                base_o[s] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                eff_o[s] <= '0;
            end else if (LEGACY && l_rise) begin
                eff_o[s] <= '0;
            end else if (LEGACY && l_fall) begin
                eff_o[s] <= base_o[s];
            end else if (wr_base && hit && (!LEGACY || !in_b64)) begin
                eff_o[s] <= wdata;
            end else if (wr_eff && hit) begin
                eff_o[s] <= wdata;
            end
        end

        if (LEGACY) begin : g_leg_chk
            // R8: entering the long code segment clears the legacy effective bases
            a_r8_rise_clears: assert property (@(posedge clk) disable iff (rst)
                l_rise |=> (eff_o[s] == '0));
            // R9: a legacy base written in 64-bit mode leaves its effective base alone
            a_r9_b64_hold: assert property (@(posedge clk) disable iff (rst)
                (wr_base && hit && in_b64 && !l_rise && !l_fall) |=> $stable(eff_o[s]));
        end
    end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
    import sysreg_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DW-1:0]     rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    output logic [MODE_W-1:0] mode_word,
    output logic              itlb_flush_all,
    output logic              dtlb_flush_all,
    output logic              itlb_flush_ng,
    output logic              dtlb_flush_ng,
    output logic              acc_err
);
    localparam logic [DW-1:0] ET_BIT = DW'(1) << C0_ET;

    logic [DW-1:0] ctl0_q, ctl2_q, ctl3_q, ctl4_q, ctl8_q;
    logic [DW-1:0] feat_q, csa_q, ssa_q, flg_q, fsw_q;
    logic [DW-1:0] dbg_q [4];
    logic [DW-1:0] dst_q, dct_q;
    logic [2:0]    top_q;
    mode_t         mode_q;
    logic          fa_q, ng_q, err_q;

    logic          wok;
    logic          w_ctl0, w_ctl3, w_ctl4, w_feat, w_csa, w_ssa, w_mode;
    logic          pg_tog, c4_tog, recompute;
    logic [DW-1:0] ctl0_nx, feat_nx, csa_nx, ssa_nx;
    mode_src_t     msrc;
    mode_t         mode_calc;
    logic          l_rise, l_fall, in_b64;
    logic [DW-1:0] tsc_val;
    logic [NSEG-1:0][DW-1:0] base_v, eff_v;

    assign wok    = wr_en && !is_reserved(wr_idx);
    assign w_ctl0 = wok && (wr_idx == IX_CTL0);
    assign w_ctl3 = wok && (wr_idx == IX_CTL3);
    assign w_ctl4 = wok && (wr_idx == IX_CTL4);
    assign w_feat = wok && (wr_idx == IX_FEAT);
    assign w_csa  = wok && (wr_idx == IX_CSA);
    assign w_ssa  = wok && (wr_idx == IX_SSA);
    assign w_mode = wok && (wr_idx == IX_MODE);

    assign pg_tog    = w_ctl0 && (wr_data[C0_PG] != ctl0_q[C0_PG]);
    assign c4_tog    = w_ctl4 && (|((wr_data ^ ctl4_q) & C4_FLUSH_MASK[DW-1:0]));
    assign recompute = w_ctl0 || w_csa || w_ssa || w_mode;

    // next values feed the mode derivation so it sees the write in flight
    always_comb begin
        ctl0_nx = w_ctl0 ? (wr_data | ET_BIT) : ctl0_q;
        csa_nx  = w_csa  ? wr_data : csa_q;
        ssa_nx  = w_ssa  ? wr_data : ssa_q;
        feat_nx = feat_q;
        if (w_feat) begin
            feat_nx = wr_data;
        end else if (pg_tog && feat_q[FT_LME]) begin
            feat_nx[FT_LMA] = wr_data[C0_PG];
        end
    end

    always_comb begin
        msrc.lma  = feat_nx[FT_LMA];
        msrc.pe   = ctl0_nx[C0_PE];
        msrc.pg   = ctl0_nx[C0_PG];
        msrc.vm   = flg_q[FL_VM];
        msrc.cs_l = csa_nx[CA_L];
        msrc.cs_d = csa_nx[CA_D];
        msrc.ss_d = ssa_nx[CA_D];
        msrc.dpl  = csa_nx[CA_DPL +: 2];
    end

    sysreg_mode_calc u_mode (
        .src  (msrc),
        .mode (mode_calc)
    );

    sysreg_tsc #(.DW(DW)) u_tsc (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wok && (wr_idx == IX_TSC)),
        .wdata (wr_data),
        .value (tsc_val)
    );

    assign l_rise = w_csa && wr_data[CA_L] && !csa_q[CA_L];
    assign l_fall = w_csa && !wr_data[CA_L] && csa_q[CA_L];
    assign in_b64 = feat_q[FT_LMA] && csa_q[CA_L];

    sysreg_seg_bank #(.DW(DW), .NS(NSEG), .NL(NLEG)) u_seg (
        .clk     (clk),
        .rst     (rst),
        .wr_base (wok && (wr_idx[5:3] == GRP_BASE)),
        .wr_eff  (wok && (wr_idx[5:3] == GRP_EFF)),
        .sel     (wr_idx[2:0]),
        .wdata   (wr_data),
        .in_b64  (in_b64),
        .l_rise  (l_rise),
        .l_fall  (l_fall),
        .base_o  (base_v),
        .eff_o   (eff_v)
    );

    // control, feature, attribute and status state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl0_q <= '0;
            ctl2_q <= '0;
            ctl3_q <= '0;
            ctl4_q <= '0;
            ctl8_q <= '0;
            feat_q <= '0;
            csa_q  <= '0;
            ssa_q  <= '0;
            flg_q  <= '0;
            fsw_q  <= '0;
            top_q  <= '0;
            mode_q <= '0;
        end else begin
            ctl0_q <= ctl0_nx;
            feat_q <= feat_nx;
            csa_q  <= csa_nx;
            ssa_q  <= ssa_nx;
            if (wok && (wr_idx == IX_CTL2)) ctl2_q <= wr_data;
            if (w_ctl3)                     ctl3_q <= wr_data;
            if (w_ctl4)                     ctl4_q <= wr_data;
            if (wok && (wr_idx == IX_CTL8)) ctl8_q <= wr_data;
            if (wok && (wr_idx == IX_FLG))  flg_q  <= wr_data;
            if (wok && (wr_idx == IX_FSW))  fsw_q  <= wr_data;
            if (wok && (wr_idx == IX_FTOP)) top_q  <= wr_data[2:0];
            if (recompute)                  mode_q <= mode_calc;
        end
    end

    // debug words; 4 and 5 fold onto status and control
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) dbg_q[k] <= '0;
            dst_q <= DST_RESET[DW-1:0];
            dct_q <= DCT_RESET[DW-1:0];
        end else if (wok) begin
            for (int k = 0; k < 4; k++) begin
                if (wr_idx == IX_DBG0 + 6'(k)) dbg_q[k] <= wr_data;
            end
            if ((wr_idx == IX_DBG4) || (wr_idx == IX_DBG6)) begin
                dst_q <= (dst_q & ~DST_WMASK[DW-1:0]) | (wr_data & DST_WMASK[DW-1:0]);
            end
            if ((wr_idx == IX_DBG5) || (wr_idx == IX_DBG7)) begin
                dct_q <= (dct_q & ~DCT_WMASK[DW-1:0]) | (wr_data & DCT_WMASK[DW-1:0]);
            end
        end
    end

    // strobes and error, one cycle after the access
    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q  <= 1'b0;
            ng_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            fa_q  <= pg_tog || c4_tog;
            ng_q  <= w_ctl3;
            err_q <= (rd_en && is_reserved(rd_idx)) || (wr_en && is_reserved(wr_idx));
        end
    end

    assign itlb_flush_all = fa_q;
    assign dtlb_flush_all = fa_q;
    assign itlb_flush_ng  = ng_q;
    assign dtlb_flush_ng  = ng_q;
    assign acc_err        = err_q;
    assign mode_word      = mode_q;

    // read mux from current state only
    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IX_CTL0: rd_data = ctl0_q;
            IX_CTL2: rd_data = ctl2_q;
            IX_CTL3: rd_data = ctl3_q;
            IX_CTL4: rd_data = ctl4_q;
            IX_CTL8: rd_data = ctl8_q;
            IX_FEAT: rd_data = feat_q;
            IX_CSA:  rd_data = csa_q;
            IX_SSA:  rd_data = ssa_q;
            IX_FLG:  rd_data = flg_q;
            IX_TSC:  rd_data = tsc_val;
            IX_FSW: begin
                rd_data = fsw_q;
                rd_data[FSW_TOP_LO +: 3] = top_q;
            end
            IX_FTOP: rd_data = DW'(top_q);
            IX_DBG0: rd_data = dbg_q[0];
            IX_DBG1: rd_data = dbg_q[1];
            IX_DBG2: rd_data = dbg_q[2];
            IX_DBG3: rd_data = dbg_q[3];
            IX_DBG4, IX_DBG6: rd_data = dst_q;
            IX_DBG5, IX_DBG7: rd_data = dct_q;
            IX_MODE: rd_data = DW'(mode_q);
            default: begin
                if (rd_idx[2:0] < 3'(NSEG)) begin
                    if (rd_idx[5:3] == GRP_BASE) rd_data = base_v[rd_idx[2:0]];
                    else if (rd_idx[5:3] == GRP_EFF) rd_data = eff_v[rd_idx[2:0]];
                end
            end
        endcase
    end

    // R2: control word 0 always carries bit 4 after a write
    a_r2_et_forced: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == IX_CTL0)) |=> ctl0_q[C0_ET]);
    // R3: a full flush only follows a control word 0 or 4 write
    a_r3_flush_src: assert property (@(posedge clk) disable iff (rst)
        itlb_flush_all |-> $past(wr_en && ((wr_idx == IX_CTL0) || (wr_idx == IX_CTL4))));
    // R4: a non-global flush only follows a control word 3 write
    a_r4_ng_src: assert property (@(posedge clk) disable iff (rst)
        itlb_flush_ng |-> $past(wr_en && (wr_idx == IX_CTL3)));
    // R7: after a recompute the protection bit tracks control word 0
    a_r7_prot_track: assert property (@(posedge clk) disable iff (rst)
        recompute |=> (mode_word[7] == ctl0_q[C0_PE]));
    // R12: bits outside the status write mask keep their reset pattern
    a_r12_dst_fixed: assert property (@(posedge clk) disable iff (rst)
        ((dst_q | DST_WMASK[DW-1:0]) == (DST_RESET[DW-1:0] | DST_WMASK[DW-1:0])));
    // R13: a reserved write leaves state alone and raises no flush
    a_r13_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_reserved(wr_idx)) |=> ($stable(ctl0_q) && $stable(mode_word) && !itlb_flush_all && !itlb_flush_ng && acc_err));
    // R13: the error pulse has a cause in the cycle before
    a_r13_err_cause: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(rd_en || wr_en));
endmodule

// File: tb/test_sysreg_file.sv
module test_sysreg_file;
    import sysreg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [63:0]       rd_data;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [63:0]       wr_data = '0;
    logic [MODE_W-1:0] mode_word;
    logic              itlb_flush_all, dtlb_flush_all, itlb_flush_ng, dtlb_flush_ng, acc_err;

    always #10 clk = ~clk;

    sysreg_file #(.DW(64)) i_sysreg_file (
        .clk            (clk),
        .rst            (rst),
        .rd_en          (rd_en),
        .rd_idx         (rd_idx),
        .rd_data        (rd_data),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_data        (wr_data),
        .mode_word      (mode_word),
        .itlb_flush_all (itlb_flush_all),
        .dtlb_flush_all (dtlb_flush_all),
        .itlb_flush_ng  (itlb_flush_ng),
        .dtlb_flush_ng  (dtlb_flush_ng),
        .acc_err        (acc_err)
    );

    typedef struct {
        bit          chk;
        logic [5:0]  ridx;
        logic [63:0] rd;
        logic [4:0]  flg;
        string       tag;
        string       ftag;
    } item_t;

    item_t       sbq[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [4:0]  pend_flg = '0;
    string       pend_tag = "R1";
    bit          done = 1'b0;

    function automatic logic [63:0] mw(int lng, int sub, int cpl, int pg, int pe,
                                       int dop, int aop, int dad, int aad, int stk);
        logic [17:0] m;
        m = {2'(stk), 2'(aad), 2'(dad), 2'(aop), 2'(dop), 1'(pe), 1'(pg), 2'(cpl), 3'(sub), 1'(lng)};
        return 64'(m);
    endfunction

    // driver: one call per clock, pushes what this window must show
    task automatic step(input bit we, input logic [5:0] wi, input logic [63:0] wd,
                        input bit re, input logic [5:0] ri, input logic [63:0] exp,
                        input logic [4:0] nflg, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd;
        rd_en = re; rd_idx = ri;
        it.chk = re; it.ridx = ri; it.rd = exp;
        it.flg = pend_flg; it.tag = tag; it.ftag = pend_tag;
        sbq.push_back(it);
        pend_flg = nflg;
        pend_tag = tag;
    endtask

    // flag vector order: {fa_i, fa_d, ng_i, ng_d, err}
    task automatic wr(input logic [5:0] i, input logic [63:0] d, input bit fa, input bit ng,
                      input bit er, input string tag);
        step(1'b1, i, d, 1'b0, 6'd0, 64'd0, {fa, fa, ng, ng, er}, tag);
    endtask

    task automatic rd(input logic [5:0] i, input logic [63:0] exp, input bit er, input string tag);
        step(1'b0, 6'd0, 64'd0, 1'b1, i, exp, {4'b0, er}, tag);
    endtask

    // monitor: samples two time units before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (sbq.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it = sbq.pop_front();
                act = {itlb_flush_all, dtlb_flush_all, itlb_flush_ng, dtlb_flush_ng, acc_err};
                n_vec++;
                if (act !== it.flg) begin
                    n_bad++;
                    $display("FAIL %s strobes act=%b exp=%b", it.ftag, act, it.flg);
                end
                if (it.chk) begin
                    n_vec++;
                    if (rd_data !== it.rd) begin
                        n_bad++;
                        $display("FAIL %s rd[%0d] act=%h exp=%h", it.tag, it.ridx, rd_data, it.rd);
                    end
                    if (it.ridx == IX_MODE) begin
                        n_vec++;
                        if (64'(mode_word) !== it.rd) begin
                            n_bad++;
                            $display("FAIL %s mode_word act=%h exp=%h", it.tag, mode_word, it.rd);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(IX_CTL0, 64'h0, 0, "R1");
        rd(IX_DBG6, 64'hFFFF_0FF0, 0, "R1");
        rd(IX_DBG7, 64'h400, 0, "R1");
        rd(IX_MODE, 64'h0, 0, "R1");
        rd(IX_FEAT, 64'h0, 0, "R1");

        // R2/R5 protection on, R6 sizes
        wr(IX_CTL0, 64'h1, 0, 0, 0, "R2");
        rd(IX_CTL0, 64'h11, 0, "R2");
        rd(IX_MODE, mw(0, 1, 0, 0, 1, 1, 2, 1, 2, 1), 0, "R5");
        // R7 flags write does not recompute; mode write recomputes and discards data
        wr(IX_FLG, 64'h2_0000, 0, 0, 0, "R7");
        rd(IX_MODE, mw(0, 1, 0, 0, 1, 1, 2, 1, 2, 1), 0, "R7");
        wr(IX_MODE, 64'hDEAD, 0, 0, 0, "R7");
        rd(IX_MODE, mw(0, 2, 0, 0, 1, 1, 2, 1, 2, 1), 0, "R7");
        // R6 code default-size, privilege 3, then stack default-size
        wr(IX_CSA, 64'hE, 0, 0, 0, "R6");
        rd(IX_MODE, mw(0, 2, 3, 0, 1, 2, 1, 2, 1, 1), 0, "R6");
        wr(IX_SSA, 64'h2, 0, 0, 0, "R6");
        rd(IX_MODE, mw(0, 2, 3, 0, 1, 2, 1, 2, 1, 2), 0, "R6");

        // R2 paging on with long enable -> long active, R3 full flush
        wr(IX_FLG, 64'h0, 0, 0, 0, "R2");
        wr(IX_FEAT, 64'h100, 0, 0, 0, "R2");
        wr(IX_CTL0, 64'h8000_0001, 1, 0, 0, "R3");
        rd(IX_FEAT, 64'h500, 0, "R2");
        rd(IX_CTL0, 64'h8000_0011, 0, "R2");
        rd(IX_MODE, mw(1, 3, 3, 1, 1, 2, 1, 2, 1, 2), 0, "R5");

        // R9 legacy base outside 64-bit mode
        wr(6'd32, 64'h1000, 0, 0, 0, "R9");
        wr(6'd35, 64'h4000, 0, 0, 0, "R9");
        rd(6'd40, 64'h1000, 0, "R9");
        // R8 long bit set clears legacy effective bases; R6 64-bit sizes
        wr(IX_CSA, 64'h1, 0, 0, 0, "R8");
        rd(6'd40, 64'h0, 0, "R8");
        rd(6'd43, 64'h0, 0, "R8");
        rd(IX_MODE, mw(1, 4, 0, 1, 1, 2, 1, 3, 2, 3), 0, "R6");
        // R9 in 64-bit mode
        wr(6'd32, 64'h2222, 0, 0, 0, "R9");
        rd(6'd32, 64'h2222, 0, "R9");
        rd(6'd40, 64'h0, 0, "R9");
        wr(6'd36, 64'h7777, 0, 0, 0, "R9");
        rd(6'd44, 64'h7777, 0, "R9");
        // R8 long bit cleared reloads effective bases
        wr(IX_CSA, 64'h0, 0, 0, 0, "R8");
        rd(6'd40, 64'h2222, 0, "R8");
        rd(6'd43, 64'h4000, 0, "R8");
        rd(IX_MODE, mw(1, 3, 0, 1, 1, 1, 2, 1, 2, 2), 0, "R6");

        // R4 non-global flush, R3 control word 4 flush rules
        wr(IX_CTL3, 64'hABC000, 0, 1, 0, "R4");
        wr(IX_CTL3, 64'hABC000, 0, 1, 0, "R4");
        wr(IX_CTL4, 64'h10, 1, 0, 0, "R3");
        wr(IX_CTL4, 64'h810, 0, 0, 0, "R3");
        wr(IX_CTL4, 64'h810, 0, 0, 0, "R3");
        rd(IX_CTL4, 64'h810, 0, "R3");

        // R2 paging off clears long active
        wr(IX_CTL0, 64'h1, 1, 0, 0, "R2");
        rd(IX_FEAT, 64'h100, 0, "R2");
        rd(IX_MODE, mw(0, 1, 0, 0, 1, 1, 2, 1, 2, 2), 0, "R5");
        // R2 without long enable, long active untouched; R5 real
        wr(IX_FEAT, 64'h0, 0, 0, 0, "R2");
        wr(IX_CTL0, 64'h8000_0000, 1, 0, 0, "R2");
        rd(IX_FEAT, 64'h0, 0, "R2");
        rd(IX_CTL0, 64'h8000_0010, 0, "R2");
        rd(IX_MODE, mw(0, 0, 0, 1, 0, 1, 2, 1, 2, 2), 0, "R5");

        // R10 timestamp
        wr(IX_TSC, 64'd1000, 0, 0, 0, "R10");
        rd(IX_TSC, 64'd1001, 0, "R10");
        rd(IX_TSC, 64'd1002, 0, "R10");
        rd(IX_TSC, 64'd1003, 0, "R10");

        // R11 stack-top merge
        wr(IX_FSW, 64'hFFFF, 0, 0, 0, "R11");
        wr(IX_FTOP, 64'h5, 0, 0, 0, "R11");
        rd(IX_FSW, 64'hEFFF, 0, "R11");
        rd(IX_FTOP, 64'h5, 0, "R11");

        // R12 debug aliases and masks
        wr(IX_DBG4, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R12");
        rd(IX_DBG6, 64'hFFFF_EFFF, 0, "R12");
        rd(IX_DBG4, 64'hFFFF_EFFF, 0, "R12");
        wr(IX_DBG5, 64'h0, 0, 0, 0, "R12");
        rd(IX_DBG7, 64'h400, 0, "R12");
        wr(IX_DBG7, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R12");
        rd(IX_DBG5, 64'hFFFF_24FF, 0, "R12");
        wr(IX_DBG1, 64'h1234, 0, 0, 0, "R12");
        rd(IX_DBG1, 64'h1234, 0, "R12");

        // R13 reserved indices
        wr(6'd1, 64'hFFFF_FFFF, 0, 0, 1, "R13");
        wr(6'd9, 64'h8000_0000, 0, 0, 1, "R13");
        rd(6'd5, 64'h0, 1, "R13");
        rd(IX_CTL0, 64'h8000_0010, 0, "R13");
        rd(IX_MODE, mw(0, 0, 0, 1, 0, 1, 2, 1, 2, 2), 0, "R13");

        // R14 same-cycle read returns old value
        wr(IX_CTL2, 64'hAAAA, 0, 0, 0, "R14");
        step(1'b1, IX_CTL2, 64'h5555, 1'b1, IX_CTL2, 64'hAAAA, 5'b0, "R14");
        rd(IX_CTL2, 64'h5555, 0, "R14");

        // drain
        step(1'b0, 6'd0, 64'd0, 1'b0, 6'd0, 64'd0, 5'b0, "R1");
        step(1'b0, 6'd0, 64'd0, 1'b0, 6'd0, 64'd0, 5'b0, "R1");
        @(negedge clk);
        wait (sbq.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule